// File: doc/BRIEF.md
# Instruction Prefetch Queue with Branch Cache

This block sits between a processor's instruction-fetch port and a flash memory that returns one 32-bit word per request, at sequential addresses in burst use. A small queue of `LINE` words keeps itself full with the instructions that follow the current fetch address. It issues one flash request whenever the bus is idle and the queue has room. After reset, fetching starts at word address 0.

A fully associative branch cache holds `NBR` entries. Each entry is tagged with a branch target and holds the first `LINE` words of that target stream. When a branch target matches a valid entry, the whole queue is loaded from the entry in the same clock edge, so the processor sees no stall. On a miss, the queue is flushed and fetching restarts at the target. The first `LINE` words that return are written into the entry that was allocated least recently. A separate extra entry is reserved for the interrupt-vector fetch, which a strobe triggers at a fixed address.

Data reads of constants stored in instruction memory share the flash bus but leave the queue alone. A synchronous invalidate input empties the cache after flash reprogramming. All addresses are word addresses.

Top module: `ifetch_prefetch_bc`

## Requirements
- R1: After reset, `fet_valid`, `fl_req` and `lit_valid` are low, and the first sequential fetch is issued at word address 0.
- R2: The fetch port offers words in ascending word-address order. `fet_data` always equals flash contents at `fet_addr`. While `fet_ready` is low, the offered word is held.
- R3: At most one flash request is outstanding. Queued words plus an in-flight sequential fetch never exceed `LINE`, so with no consumer exactly `LINE` requests follow a branch miss.
- R4: On a branch (`br_valid`) whose target misses, `fet_valid` is low in the next cycle, and the next flash request carries the target address.
- R5: On a branch whose target hits, `fet_valid` is high with `fet_addr` equal to the target in the next cycle. The `LINE` cached words are delivered in `LINE` consecutive cycles, and sequential fetching then continues at target+`LINE`.
- R6: A miss allocates one of the `NBR` branch entries in least-recently-allocated order. That entry captures the target word and the next `LINE-1` words, after which later branches to that target hit.
- R7: The `vec_req` strobe redirects fetch to `VEC_ADDR` using the reserved entry. The first strobe misses and fills that entry, and later strobes hit even after `NBR` or more branch misses. `vec_req` takes priority over `br_valid`.
- R8: A `lit_req` pulse produces one `lit_valid` pulse with flash contents at `lit_addr`. It issues exactly one flash request, and the queue contents and head address stay unchanged.
- R9: A `bc_inv` pulse invalidates every cache entry, so a branch to a previously cached target misses afterwards.
- R10: A redirect while a sequential fetch is in flight discards that fetch's result. Any capture still in progress is abandoned, so its entry stays invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Taken branch this cycle |
| br_target | input | AW | Branch target word address |
| vec_req | input | 1 | Interrupt-vector fetch strobe |
| fet_ready | input | 1 | Processor accepts the offered word |
| fet_valid | output | 1 | A fetched word is offered |
| fet_addr | output | AW | Word address of the offered word |
| fet_data | output | DW | Offered instruction word |
| lit_req | input | 1 | Constant-read request pulse |
| lit_addr | input | AW | Constant-read word address |
| lit_valid | output | 1 | Constant-read result pulse |
| lit_data | output | DW | Constant-read result |
| bc_inv | input | 1 | Invalidate all cache entries |
| fl_req | output | 1 | Flash request pulse |
| fl_addr | output | AW | Flash request word address |
| fl_rvalid | input | 1 | Flash response valid |
| fl_rdata | input | DW | Flash response word |

## Verification
On every cycle, the assertions check the following:
- there is only ever one outstanding request;
- the queue plus in-flight words stay within the queue depth;
- a hit makes the target word valid on the very next cycle;
- a miss empties the queue;
- a constant read leaves the queue occupancy and head address unchanged;
- cache tags stay unique, and an entry being captured is never valid.

Only the bench scenarios can show the following:
- the delivered data are the right flash words across several flash latencies;
- replacement follows allocation order;
- the vector entry survives branch traffic;
- invalidation and abandoned captures turn later branches into misses.

// File: rtl/ifp_pkg.sv
package ifp_pkg;
  // Kind of the single flash transfer in flight
  typedef enum logic {
    KIND_SEQ = 1'b0,
    KIND_LIT = 1'b1
  } req_kind_e;
endpackage

// File: rtl/ifp_queue.sv
// Prefetch word queue; DEPTH must be a power of two.
module ifp_queue #(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic                bulk,
  input  logic [DEPTH*DW-1:0] bulk_data,
  input  logic                push,
  input  logic [DW-1:0]       push_data,
  input  logic                pop,
  output logic [DW-1:0]       head,
  output logic [CW-1:0]       count
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt_q;

  assign head  = mem[rd_ptr];
  assign count = cnt_q;

  always_ff @(posedge clk) begin
    if (bulk) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= bulk_data[i*DW +: DW];
    end else if (push && !flush) begin
      mem[wr_ptr] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt_q  <= '0;
    end else if (bulk) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt_q  <= CW'(DEPTH);
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PW'(1);
      if (pop)  rd_ptr <= rd_ptr + PW'(1);
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !bulk && !flush) |-> (cnt_q < CW'(DEPTH))); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (pop && !bulk && !flush) |-> (cnt_q != '0)); // R2
endmodule

// File: rtl/ifp_bcache.sv
// Branch target cache: NBR FIFO-replaced entries plus one reserved vector entry.
module ifp_bcache #(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int LINE = 4,
  parameter int NBR  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inv,
  input  logic               look_vec,
  input  logic [AW-1:0]      look_tag,
  output logic               hit,
  output logic [LINE*DW-1:0] hit_line,
  input  logic               alloc,
  input  logic               alloc_vec,
  input  logic [AW-1:0]      alloc_tag,
  input  logic               abort,
  input  logic               wr_en,
  input  logic [DW-1:0]      wr_data
);
  localparam int NE = NBR + 1;
  localparam int IW = $clog2(NE);
  localparam int LW = $clog2(LINE);
  localparam int FW = $clog2(NBR);

  logic [AW-1:0] tag_q  [NE];
  logic [DW-1:0] data_q [NE][LINE];
  logic [NE-1:0] vld_q;
  logic [FW-1:0] fifo_q;
  logic          cap_on;
  logic [IW-1:0] cap_idx;
  logic [LW-1:0] cap_cnt;

  logic [NBR-1:0] match;
  logic [IW-1:0]  hit_idx, alloc_idx;
  logic           hit_any;

  always_comb begin
    hit_idx = IW'(NBR);
    hit_any = 1'b0;
    match   = '0;
    for (int i = 0; i < NBR; i++) begin
      match[i] = vld_q[i] && (tag_q[i] == look_tag);
    end
    if (look_vec) begin
      hit_any = vld_q[NBR];
    end else begin
      for (int i = 0; i < NBR; i++) begin
        if (match[i]) begin
          hit_any = 1'b1;
          hit_idx = IW'(i);
        end
      end
    end
  end

  assign hit       = hit_any && !inv;
  assign alloc_idx = alloc_vec ? IW'(NBR) : IW'(fifo_q);

  for (genvar w = 0; w < LINE; w++) begin : g_line
    assign hit_line[w*DW +: DW] = data_q[hit_idx][w];
  end

  always_ff @(posedge clk) begin
    if (alloc) tag_q[alloc_idx] <= alloc_tag;
    if (wr_en && cap_on && !inv && !abort) data_q[cap_idx][cap_cnt] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q   <= '0;
      fifo_q  <= '0;
      cap_on  <= 1'b0;
      cap_idx <= '0;
      cap_cnt <= '0;
    end else begin
      if (wr_en && cap_on) begin
        cap_cnt <= cap_cnt + LW'(1);
        if (cap_cnt == LW'(LINE - 1)) begin
          vld_q[cap_idx] <= 1'b1;
          cap_on         <= 1'b0;
        end
      end
      if (inv) begin
        vld_q  <= '0;
        cap_on <= 1'b0;
      end
      if (abort) cap_on <= 1'b0;
      if (alloc) begin
        vld_q[alloc_idx] <= 1'b0;
        cap_on           <= 1'b1;
        cap_idx          <= alloc_idx;
        cap_cnt          <= '0;
        if (!alloc_vec) fifo_q <= (fifo_q == FW'(NBR - 1)) ? '0 : fifo_q + FW'(1);
      end
    end
  end

  AST_CAP_ENTRY_INVALID: assert property (@(posedge clk) disable iff (rst)
    cap_on |-> !vld_q[cap_idx]); // R6
  AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (rst)
    $countones(match) <= 1); // R6
endmodule

// File: rtl/ifetch_prefetch_bc.sv
module ifetch_prefetch_bc
  import ifp_pkg::*;
#(
  parameter int            AW       = 16,
  parameter int            DW       = 32,
  parameter int            LINE     = 4,
  parameter int            NBR      = 4,
  parameter logic [AW-1:0] VEC_ADDR = 16'h0040
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          br_valid,
  input  logic [AW-1:0] br_target,
  input  logic          vec_req,
  input  logic          fet_ready,
  output logic          fet_valid,
  output logic [AW-1:0] fet_addr,
  output logic [DW-1:0] fet_data,
  input  logic          lit_req,
  input  logic [AW-1:0] lit_addr,
  output logic          lit_valid,
  output logic [DW-1:0] lit_data,
  input  logic          bc_inv,
  output logic          fl_req,
  output logic [AW-1:0] fl_addr,
  input  logic          fl_rvalid,
  input  logic [DW-1:0] fl_rdata
);
  localparam int CW = $clog2(LINE + 1);

  logic               redirect, bc_hit, pop, resp_seq, issue_lit, issue_seq, live_seq;
  logic [AW-1:0]      tgt;
  logic [LINE*DW-1:0] bc_line;
  logic [CW-1:0]      q_cnt;
  logic [DW-1:0]      q_head;

  logic          out_q, drop_q, lit_pend_q, fl_req_q, lit_valid_q;
  req_kind_e     kind_q;
  logic [AW-1:0] pf_addr_q, head_addr_q, lit_addr_q, fl_addr_q;
  logic [DW-1:0] lit_data_q;

  assign redirect  = br_valid || vec_req;
  assign tgt       = vec_req ? VEC_ADDR : br_target;
  assign fet_valid = (q_cnt != '0);
  assign pop       = fet_valid && fet_ready && !redirect;
  assign resp_seq  = fl_rvalid && out_q && (kind_q == KIND_SEQ) && !drop_q && !redirect;
  assign issue_lit = !out_q && lit_pend_q;
  assign issue_seq = !out_q && !lit_pend_q && !redirect && (q_cnt < CW'(LINE));
  assign live_seq  = out_q && (kind_q == KIND_SEQ) && !drop_q;

  assign fet_addr  = head_addr_q;
  assign fet_data  = q_head;
  assign fl_req    = fl_req_q;
  assign fl_addr   = fl_addr_q;
  assign lit_valid = lit_valid_q;
  assign lit_data  = lit_data_q;

  ifp_queue #(.DW(DW), .DEPTH(LINE)) i_queue (
    .clk       (clk),
    .rst       (rst),
    .flush     (redirect && !bc_hit),
    .bulk      (redirect && bc_hit),
    .bulk_data (bc_line),
    .push      (resp_seq),
    .push_data (fl_rdata),
    .pop       (pop),
    .head      (q_head),
    .count     (q_cnt)
  );

  ifp_bcache #(.AW(AW), .DW(DW), .LINE(LINE), .NBR(NBR)) i_bcache (
    .clk       (clk),
    .rst       (rst),
    .inv       (bc_inv),
    .look_vec  (vec_req),
    .look_tag  (tgt),
    .hit       (bc_hit),
    .hit_line  (bc_line),
    .alloc     (redirect && !bc_hit),
    .alloc_vec (vec_req),
    .alloc_tag (tgt),
    .abort     (redirect),
    .wr_en     (resp_seq),
    .wr_data   (fl_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q       <= 1'b0;
      kind_q      <= KIND_SEQ;
      drop_q      <= 1'b0;
      lit_pend_q  <= 1'b0;
      lit_addr_q  <= '0;
      fl_req_q    <= 1'b0;
      fl_addr_q   <= '0;
      lit_valid_q <= 1'b0;
      lit_data_q  <= '0;
      pf_addr_q   <= '0;
      head_addr_q <= '0;
    end else begin
      fl_req_q    <= 1'b0;
      lit_valid_q <= 1'b0;
      if (fl_rvalid && out_q) begin
        out_q  <= 1'b0;
        drop_q <= 1'b0;
        if (kind_q == KIND_LIT) begin
          lit_valid_q <= 1'b1;
          lit_data_q  <= fl_rdata;
        end
      end else if (redirect && out_q && (kind_q == KIND_SEQ)) begin
        drop_q <= 1'b1;
      end
      if (redirect) begin
        head_addr_q <= tgt;
        pf_addr_q   <= bc_hit ? tgt + AW'(LINE) : tgt;
      end else if (pop) begin
        head_addr_q <= head_addr_q + AW'(1);
      end
      if (issue_lit) begin
        fl_req_q   <= 1'b1;
        fl_addr_q  <= lit_addr_q;
        out_q      <= 1'b1;
        kind_q     <= KIND_LIT;
        lit_pend_q <= 1'b0;
      end else if (issue_seq) begin
        fl_req_q  <= 1'b1;
        fl_addr_q <= pf_addr_q;
        pf_addr_q <= pf_addr_q + AW'(1);
        out_q     <= 1'b1;
        kind_q    <= KIND_SEQ;
      end
      if (lit_req) begin
        lit_pend_q <= 1'b1;
        lit_addr_q <= lit_addr;
      end
    end
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    (fl_req && !fl_rvalid) |=> !fl_req); // R3
  AST_PREFETCH_BOUND: assert property (@(posedge clk) disable iff (rst)
    (int'(q_cnt) + int'(live_seq)) <= LINE); // R3
  AST_HIT_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    (redirect && bc_hit) |=> (fet_valid && (fet_addr == $past(tgt)))); // R5
  AST_MISS_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (redirect && !bc_hit) |=> !fet_valid); // R4
  AST_LIT_KEEPS_QUEUE: assert property (@(posedge clk) disable iff (rst)
    (fl_rvalid && out_q && (kind_q == KIND_LIT) && !redirect && !pop)
      |=> ((q_cnt == $past(q_cnt)) && (fet_addr == $past(fet_addr)))); // R8
endmodule

// File: tb/test_ifetch_prefetch_bc.sv
module test_ifetch_prefetch_bc;
  localparam logic [15:0] VEC = 16'h0040;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        br_valid = 1'b0, vec_req = 1'b0, fet_ready = 1'b0;
  logic [15:0] br_target = '0, lit_addr = '0;
  logic        lit_req = 1'b0, bc_inv = 1'b0;
  logic        fet_valid, lit_valid, fl_req;
  logic [15:0] fet_addr, fl_addr;
  logic [31:0] fet_data, lit_data;
  logic        fl_rvalid = 1'b0;
  logic [31:0] fl_rdata = '0;

  int checks = 0, fails = 0;
  int fl_lat = 2, fl_wait = 0, req_cnt = 0;
  logic fl_busy = 1'b0, want_first = 1'b0;
  logic [15:0] fl_a = '0, first_addr = '0;

  always #2.5 clk = ~clk;

  ifetch_prefetch_bc i_ifetch_prefetch_bc (
    .clk(clk), .rst(rst), .br_valid(br_valid), .br_target(br_target),
    .vec_req(vec_req), .fet_ready(fet_ready), .fet_valid(fet_valid),
    .fet_addr(fet_addr), .fet_data(fet_data), .lit_req(lit_req),
    .lit_addr(lit_addr), .lit_valid(lit_valid), .lit_data(lit_data),
    .bc_inv(bc_inv), .fl_req(fl_req), .fl_addr(fl_addr),
    .fl_rvalid(fl_rvalid), .fl_rdata(fl_rdata)
  );

  function automatic logic [31:0] mem_word(input logic [15:0] a);
    return {a ^ 16'h5A3C, a + 16'h1234};
  endfunction

  // Flash model: answers fl_lat cycles after a request
  always @(negedge clk) begin
    if (rst) begin
      fl_rvalid = 1'b0;
      fl_busy   = 1'b0;
    end else begin
      fl_rvalid = 1'b0;
      if (fl_busy) begin
        if (fl_wait == 0) begin
          fl_rvalid = 1'b1;
          fl_rdata  = mem_word(fl_a);
          fl_busy   = 1'b0;
        end else fl_wait--;
      end
      if (fl_req) begin
        fl_busy = 1'b1;
        fl_a    = fl_addr;
        fl_wait = fl_lat - 1;
        req_cnt++;
        if (want_first) begin
          first_addr = fl_addr;
          want_first = 1'b0;
        end
      end
    end
  end

  task automatic expect_eq(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic branch(input logic [15:0] t);
    @(negedge clk);
    br_valid = 1'b1;
    br_target = t;
    @(negedge clk);
    br_valid = 1'b0;
    want_first = 1'b1;
  endtask

  task automatic vector();
    @(negedge clk);
    vec_req = 1'b1;
    @(negedge clk);
    vec_req = 1'b0;
    want_first = 1'b1;
  endtask

  task automatic pop_n(input int n, input logic [15:0] start, input string req, output int cyc);
    logic [15:0] e;
    int got;
    e = start;
    got = 0;
    cyc = 0;
    fet_ready = 1'b1;
    while (got < n && cyc < 300) begin
      if (fet_valid) begin
        expect_eq(req, "fet_addr", 32'(fet_addr), 32'(e));
        expect_eq(req, "fet_data", fet_data, mem_word(e));
        e++;
        got++;
      end
      cyc++;
      @(negedge clk);
    end
    fet_ready = 1'b0;
    expect_eq(req, "words delivered", got, n);
  endtask

  task automatic miss_fill(input logic [15:0] t, input string req);
    int c;
    branch(t);
    expect_eq(req, "fet_valid after miss", fet_valid, 0);
    pop_n(LINE_W, t, req, c);
    expect_eq(req, "first request address", 32'(first_addr), 32'(t));
  endtask

  task automatic hit_check(input logic [15:0] t, input string req);
    int c;
    branch(t);
    expect_eq(req, "fet_valid after hit", fet_valid, 1);
    pop_n(LINE_W, t, req, c);
    expect_eq(req, "cycles for cached line", c, LINE_W);
  endtask

  localparam int LINE_W = 4;

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int c, rc0;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    expect_eq("R1", "fet_valid in reset", fet_valid, 0);
    expect_eq("R1", "fl_req in reset", fl_req, 0);
    expect_eq("R1", "lit_valid in reset", lit_valid, 0);
    want_first = 1'b1;
    rst = 1'b0;
    pop_n(3, 16'h0000, "R1", c);
    expect_eq("R1", "first fetch address", 32'(first_addr), 0);

    // R2, R4: latency sweep over sequential streams after misses
    for (int lat = 1; lat <= 4; lat++) begin
      fl_lat = lat;
      branch(16'h0800 + 16'(lat * 64));
      expect_eq("R4", "fet_valid after miss", fet_valid, 0);
      pop_n(12, 16'h0800 + 16'(lat * 64), "R2", c);
      expect_eq("R4", "first request address", 32'(first_addr), 32'(16'h0800 + 16'(lat * 64)));
    end
    fl_lat = 2;

    // R3: no consumer, exactly LINE requests; R2: head held
    branch(16'h2000);
    rc0 = req_cnt;
    repeat (30) @(negedge clk);
    expect_eq("R3", "requests with full queue", req_cnt - rc0, LINE_W);
    held = fet_addr;
    repeat (5) @(negedge clk);
    expect_eq("R2", "head held while not ready", 32'(fet_addr), 32'(held));
    expect_eq("R2", "head address", 32'(fet_addr), 32'h2000);
    pop_n(6, 16'h2000, "R2", c);

    // R5: hit reloads queue, then fetch continues at target+LINE
    hit_check(16'h2000, "R5");
    pop_n(4, 16'h2004, "R5", c);

    // R6: FIFO replacement; R9: invalidate
    @(negedge clk); bc_inv = 1'b1; @(negedge clk); bc_inv = 1'b0;
    branch(16'h2000);
    expect_eq("R9", "fet_valid after invalidated target", fet_valid, 0);
    pop_n(4, 16'h2000, "R9", c);
    @(negedge clk); bc_inv = 1'b1; @(negedge clk); bc_inv = 1'b0;
    for (int i = 0; i < 5; i++) miss_fill(16'h3000 + 16'(i * 256), "R6");
    for (int i = 1; i < 5; i++) hit_check(16'h3000 + 16'(i * 256), "R6");
    miss_fill(16'h3000, "R6");
    miss_fill(16'h3100, "R6");
    hit_check(16'h3300, "R6");
    @(negedge clk); bc_inv = 1'b1; @(negedge clk); bc_inv = 1'b0;
    miss_fill(16'h3300, "R9");

    // R7: vector entry
    vector();
    expect_eq("R7", "fet_valid after first vector", fet_valid, 0);
    pop_n(4, VEC, "R7", c);
    expect_eq("R7", "vector request address", 32'(first_addr), 32'(VEC));
    for (int i = 0; i < 5; i++) miss_fill(16'h4000 + 16'(i * 256), "R7");
    vector();
    expect_eq("R7", "fet_valid after second vector", fet_valid, 1);
    pop_n(4, VEC, "R7", c);
    expect_eq("R7", "cycles for vector line", c, 4);

    // R8: literal read with full queue
    branch(16'h5000);
    repeat (20) @(negedge clk);
    rc0 = req_cnt;
    lit_addr = 16'h7777; lit_req = 1'b1;
    @(negedge clk); lit_req = 1'b0;
    c = 0;
    while (!lit_valid && c < 50) begin @(negedge clk); c++; end
    expect_eq("R8", "lit_valid seen", lit_valid, 1);
    expect_eq("R8", "lit_data", lit_data, mem_word(16'h7777));
    expect_eq("R8", "requests for literal", req_cnt - rc0, 1);
    expect_eq("R8", "queue head kept", 32'(fet_addr), 32'h5000);
    expect_eq("R8", "queue still valid", fet_valid, 1);
    pop_n(8, 16'h5000, "R8", c);
    // R8: literal while a sequential fetch is in flight
    branch(16'h5800);
    lit_addr = 16'h0123; lit_req = 1'b1;
    @(negedge clk); lit_req = 1'b0;
    c = 0;
    while (!lit_valid && c < 50) begin @(negedge clk); c++; end
    expect_eq("R8", "lit_data in flight", lit_data, mem_word(16'h0123));
    pop_n(6, 16'h5800, "R8", c);

    // R10: redirect during an in-flight fetch and an unfinished capture
    fl_lat = 4;
    branch(16'h6000);
    @(negedge clk);
    branch(16'h6800);
    pop_n(6, 16'h6800, "R10", c);
    expect_eq("R10", "first request after redirect", 32'(first_addr), 32'h6800);
    branch(16'h6000);
    expect_eq("R10", "abandoned capture misses", fet_valid, 0);
    pop_n(4, 16'h6000, "R10", c);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule